// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Three tables of single-bit entries do the work. A per-branch table records what each branch did the last time it resolved. A second table is addressed by combining recent branch outcomes with the branch address. A chooser table, indexed per branch, remembers which of those two has been right more recently for that branch and picks which one drives the answer. A static mode input can bypass the tables and force a fixed answer.

The fetch side presents a branch address on the lookup port and gets a prediction in the same cycle. It also gets the global-table index used for that prediction, and it returns that index later on the update port. The execute side uses the update port to report the resolved outcome. The tables are trained at that point and the outcome is shifted into the global history register. History changes only at resolution and is never updated speculatively.

Top module: `tourney_predictor`

## Requirements
- R1: On reset every table bit and the history register clear to zero, so the first dynamic lookups predict not-taken.
- R2: `mode_i` 2'b01 forces the prediction to 0 (not taken) and 2'b10 forces it to 1 (taken). Encodings 2'b00 and 2'b11 select the dynamic prediction.
- R3: The per-branch index is `pc[IDX_W+1:2]`. `lk_gidx_o` is that index with its low HIST_W bits XORed with the history register, valid in the same cycle as the lookup address.
- R4: A valid update overwrites the per-branch last-outcome entry at the update address's index with the actual outcome, visible from the next cycle.
- R5: A valid update overwrites the global-table entry at `up_gidx_i` with the actual outcome, whatever the history has become since the lookup.
- R6: The dynamic prediction is the global-table bit when the chooser bit is 1 and the last-outcome bit when it is 0. The chooser bit is written only when the two tables' current bits at the update indices differ. It is set to 1 if the global bit equalled the outcome and to 0 otherwise.
- R7: Each valid update shifts the history left by one and inserts the outcome at bit 0. Without an update the history holds.
- R8: A lookup in the same cycle as an update reads the tables as they were before that cycle's write.
- R9: Training and history updates happen in every mode, including the two forced modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | 00/11 dynamic, 01 force not-taken, 10 force taken |
| lk_pc_i | input | ADDR_W | Lookup branch address |
| lk_pred_o | output | 1 | Prediction for the lookup address, 1 = taken |
| lk_gidx_o | output | IDX_W | Global-table index used for this lookup |
| up_valid_i | input | 1 | Update strobe |
| up_pc_i | input | ADDR_W | Address of the resolved branch |
| up_gidx_i | input | IDX_W | Global index returned from the branch's lookup |
| up_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
Both lookup outputs are combinational. The bench therefore samples them at the falling edge of the cycle in which the address is driven. An update takes effect at the next rising edge, so its result first shows on a lookup in the following cycle. The driver task builds each expected prediction and index from a reference model. That model absorbs an update only after the rising edge that commits it, which also covers the same-cycle read-before-write case. A monitor pops the expected values at every falling edge and compares them.

// File: rtl/tourney_bp_pkg.sv
// Shared definitions for the tournament predictor: the mode encoding.
package tourney_bp_pkg;
    typedef enum logic [1:0] {
        MODE_DYNAMIC  = 2'b00,
        MODE_FORCE_NT = 2'b01,
        MODE_FORCE_TK = 2'b10,
        MODE_DYN_ALT  = 2'b11
    } bp_mode_e;
endpackage

// File: rtl/tbp_bit_table.sv
// One-bit-per-entry storage table. Reads are done by the parent from the
// exposed contents; one entry is written per cycle. Assumes ENTRIES = 2**IDX_W.
module tbp_bit_table #(
    parameter int IDX_W   = 11,
    parameter int ENTRIES = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [IDX_W-1:0]   widx_i,
    input  logic               wbit_i,
    output logic [ENTRIES-1:0] bits_o
);
    logic [ENTRIES-1:0] bits_q;

    // Clear on reset, otherwise write the addressed bit when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bits_q <= '0;
        else if (we_i)
            bits_q[widx_i] <= wbit_i;
    end

    assign bits_o = bits_q;
endmodule

// File: rtl/tbp_ghist.sv
// Global outcome history: shifts left with the new outcome entering bit 0.
// Assumes shifting happens only at branch resolution.
module tbp_ghist #(
    parameter int HIST_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [HIST_W-1:0] hist_o
);
    logic [HIST_W-1:0] hist_q;

    // Clear on reset, shift in the resolved outcome on each update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q <= '0;
        else if (shift_i)
            hist_q <= {hist_q[HIST_W-2:0], bit_i};
    end

    assign hist_o = hist_q;
endmodule

// File: rtl/tourney_predictor.sv
// Tournament direction predictor: last-outcome table, history-indexed table
// and a per-branch chooser, all one bit per entry. Lookup is combinational;
// update writes at the clock edge, so same-cycle lookups see old contents.
// Assumes 2 <= HIST_W <= IDX_W and ADDR_W > IDX_W + 2.
module tourney_predictor
    import tourney_bp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 11,
    parameter int HIST_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] lk_pc_i,
    output logic              lk_pred_o,
    output logic [IDX_W-1:0]  lk_gidx_o,
    input  logic              up_valid_i,
    input  logic [ADDR_W-1:0] up_pc_i,
    input  logic [IDX_W-1:0]  up_gidx_i,
    input  logic              up_taken_i
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] loc_bits, glb_bits, cho_bits;
    logic [HIST_W-1:0]  hist_q;
    logic [IDX_W-1:0]   lk_lidx, up_lidx;
    logic               lk_loc, lk_glb, lk_sel, lk_dyn;
    logic               up_loc_rd, up_glb_rd, cho_we, cho_bit;
    logic               unused_pc_bits;

    // Per-branch index from word-aligned address bits.
    assign lk_lidx = lk_pc_i[IDX_W+1:2];
    assign up_lidx = up_pc_i[IDX_W+1:2];
    assign unused_pc_bits = ^{lk_pc_i[ADDR_W-1:IDX_W+2], lk_pc_i[1:0],
                              up_pc_i[ADDR_W-1:IDX_W+2], up_pc_i[1:0]};

    // Fold history into the low bits of the per-branch index.
    generate
        if (HIST_W == IDX_W) begin : g_full_fold
            assign lk_gidx_o = lk_lidx ^ hist_q;
        end else begin : g_part_fold
            assign lk_gidx_o = {lk_lidx[IDX_W-1:HIST_W],
                                lk_lidx[HIST_W-1:0] ^ hist_q};
        end
    endgenerate

    // Lookup reads and chooser selection.
    assign lk_loc = loc_bits[lk_lidx];
    assign lk_glb = glb_bits[lk_gidx_o];
    assign lk_sel = cho_bits[lk_lidx];
    assign lk_dyn = lk_sel ? lk_glb : lk_loc;

    // Static modes override the table result.
    always_comb begin
        case (bp_mode_e'(mode_i))
            MODE_FORCE_NT: lk_pred_o = 1'b0;
            MODE_FORCE_TK: lk_pred_o = 1'b1;
            default:       lk_pred_o = lk_dyn;
        endcase
    end

    // Update-side reads decide whether the chooser learns.
    assign up_loc_rd = loc_bits[up_lidx];
    assign up_glb_rd = glb_bits[up_gidx_i];
    assign cho_we    = up_valid_i && (up_loc_rd != up_glb_rd);
    assign cho_bit   = (up_glb_rd == up_taken_i);

    tbp_bit_table #(.IDX_W(IDX_W), .ENTRIES(ENTRIES)) u_local (
        .clk(clk), .rst_n(rst_n), .we_i(up_valid_i), .widx_i(up_lidx),
        .wbit_i(up_taken_i), .bits_o(loc_bits)
    );

    tbp_bit_table #(.IDX_W(IDX_W), .ENTRIES(ENTRIES)) u_global (
        .clk(clk), .rst_n(rst_n), .we_i(up_valid_i), .widx_i(up_gidx_i),
        .wbit_i(up_taken_i), .bits_o(glb_bits)
    );

    tbp_bit_table #(.IDX_W(IDX_W), .ENTRIES(ENTRIES)) u_chooser (
        .clk(clk), .rst_n(rst_n), .we_i(cho_we), .widx_i(up_lidx),
        .wbit_i(cho_bit), .bits_o(cho_bits)
    );

    tbp_ghist #(.HIST_W(HIST_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .shift_i(up_valid_i),
        .bit_i(up_taken_i), .hist_o(hist_q)
    );
endmodule

// File: rtl/tourney_predictor_chk.sv
// Property checker for tourney_predictor, attached by bind below.
module tourney_predictor_chk #(
    parameter int IDX_W  = 11,
    parameter int HIST_W = 11,
    parameter int ENTRIES = 1 << IDX_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         mode_i,
    input logic               lk_pred_o,
    input logic               up_valid_i,
    input logic               up_taken_i,
    input logic [IDX_W-1:0]   up_lidx,
    input logic [IDX_W-1:0]   up_gidx_i,
    input logic               up_loc_rd,
    input logic               up_glb_rd,
    input logic [HIST_W-1:0]  hist_q,
    input logic [ENTRIES-1:0] loc_bits,
    input logic [ENTRIES-1:0] glb_bits,
    input logic [ENTRIES-1:0] cho_bits
);
    AST_FORCE_NT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01) |-> !lk_pred_o);                                   // R2
    AST_FORCE_TK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10) |-> lk_pred_o);                                    // R2
    AST_LOCAL_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid_i |=> loc_bits[$past(up_lidx)] == $past(up_taken_i));     // R4
    AST_GLOBAL_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid_i |=> glb_bits[$past(up_gidx_i)] == $past(up_taken_i));   // R5
    AST_CHOOSER_LEARN: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid_i && (up_loc_rd != up_glb_rd)) |=>
        cho_bits[$past(up_lidx)] == ($past(up_glb_rd) == $past(up_taken_i))); // R6
    AST_CHOOSER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid_i && (up_loc_rd == up_glb_rd)) |=>
        cho_bits[$past(up_lidx)] == $past(cho_bits[up_lidx]));               // R6
    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid_i |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(up_taken_i)}); // R7
    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid_i |=> $stable(hist_q));                                    // R7
endmodule

bind tourney_predictor tourney_predictor_chk #(
    .IDX_W(IDX_W), .HIST_W(HIST_W), .ENTRIES(ENTRIES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .lk_pred_o(lk_pred_o),
    .up_valid_i(up_valid_i), .up_taken_i(up_taken_i), .up_lidx(up_lidx),
    .up_gidx_i(up_gidx_i), .up_loc_rd(up_loc_rd), .up_glb_rd(up_glb_rd),
    .hist_q(hist_q), .loc_bits(loc_bits), .glb_bits(glb_bits),
    .cho_bits(cho_bits)
);

// File: tb/tourney_predictor_tb_top.sv
// Scoreboard bench: the driver pushes model expectations, the monitor compares.
module tourney_predictor_tb_top;
    localparam int ADDR_W  = 32;
    localparam int IDX_W   = 11;
    localparam int HIST_W  = 11;
    localparam int ENTRIES = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode_i = 2'b00;
    logic [ADDR_W-1:0] lk_pc_i = '0;
    logic              lk_pred_o;
    logic [IDX_W-1:0]  lk_gidx_o;
    logic              up_valid_i = 1'b0;
    logic [ADDR_W-1:0] up_pc_i = '0;
    logic [IDX_W-1:0]  up_gidx_i = '0;
    logic              up_taken_i = 1'b0;

    always #5 clk = ~clk;

    tourney_predictor #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .lk_pc_i(lk_pc_i),
        .lk_pred_o(lk_pred_o), .lk_gidx_o(lk_gidx_o), .up_valid_i(up_valid_i),
        .up_pc_i(up_pc_i), .up_gidx_i(up_gidx_i), .up_taken_i(up_taken_i)
    );

    typedef struct {
        logic             pred;
        logic [IDX_W-1:0] gidx;
        string            tag;
    } exp_t;

    typedef struct {
        logic [ADDR_W-1:0] pc;
        logic [IDX_W-1:0]  g;
        logic              tk;
    } pend_t;

    exp_t  sb_q[$];
    pend_t pend_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;

    // Reference model state.
    logic [ENTRIES-1:0] m_loc = '0, m_glb = '0, m_cho = '0;
    logic [HIST_W-1:0]  m_hist = '0;

    function automatic logic [IDX_W-1:0] m_lidx(input logic [ADDR_W-1:0] pc);
        return pc[IDX_W+1:2];
    endfunction

    function automatic logic [IDX_W-1:0] m_gidx(input logic [ADDR_W-1:0] pc);
        return m_lidx(pc) ^ IDX_W'(m_hist);
    endfunction

    function automatic logic m_pred(input logic [ADDR_W-1:0] pc, input logic [1:0] md);
        logic [IDX_W-1:0] li;
        li = m_lidx(pc);
        if (md == 2'b01) return 1'b0;
        if (md == 2'b10) return 1'b1;
        return m_cho[li] ? m_glb[m_gidx(pc)] : m_loc[li];
    endfunction

    task automatic m_update(input logic [ADDR_W-1:0] pc, input logic [IDX_W-1:0] g,
                            input logic tk);
        logic [IDX_W-1:0] li;
        logic lr, gr;
        li = m_lidx(pc);
        lr = m_loc[li];
        gr = m_glb[g];
        if (lr != gr) m_cho[li] = (gr == tk);
        m_loc[li] = tk;
        m_glb[g]  = tk;
        m_hist    = {m_hist[HIST_W-2:0], tk};
    endtask

    // Driver: one cycle of lookup plus optional update; called just after a rising edge.
    task automatic step(input logic [ADDR_W-1:0] pc, input logic [1:0] md,
                        input logic uv, input logic [ADDR_W-1:0] upc,
                        input logic [IDX_W-1:0] ug, input logic utk, input string tag);
        exp_t e;
        #1;
        mode_i = md; lk_pc_i = pc;
        up_valid_i = uv; up_pc_i = upc; up_gidx_i = ug; up_taken_i = utk;
        e.pred = m_pred(pc, md);
        e.gidx = m_gidx(pc);
        e.tag  = tag;
        sb_q.push_back(e);
        @(posedge clk);
        if (uv) m_update(upc, ug, utk);
    endtask

    task automatic look(input logic [ADDR_W-1:0] pc, input logic [1:0] md, input string tag);
        step(pc, md, 1'b0, '0, '0, 1'b0, tag);
    endtask

    // Monitor: compare combinational outputs at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (lk_pred_o !== e.pred || lk_gidx_o !== e.gidx) begin
                    failures++;
                    $display("FAIL %s pred=%0b exp=%0b gidx=%0h exp=%0h",
                             e.tag, lk_pred_o, e.pred, lk_gidx_o, e.gidx);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] pcs [8];
        int cnt [8];
        pcs = '{32'h0000_0040, 32'h0000_0044, 32'h0000_1040, 32'h0000_0100,
                32'h0000_2204, 32'h0000_0048, 32'h0000_0c40, 32'h0000_3ffc};
        foreach (cnt[i]) cnt[i] = 0;

        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);

        // R1 reset state: not taken, index equals per-branch index.
        look(32'h0000_0100, 2'b00, "R1 reset lookup");
        look(32'h0000_2004, 2'b11, "R1 reset lookup alt dynamic");
        // R2 forced modes on an untrained predictor.
        look(32'h0000_0100, 2'b10, "R2 force taken");
        look(32'h0000_0100, 2'b01, "R2 force not-taken");
        // R4 and R7: train 0x40 taken, then look up again.
        step(32'h0000_0040, 2'b00, 1'b1, 32'h0000_0040, m_gidx(32'h40), 1'b1,
             "R8 lookup during update sees old contents");
        look(32'h0000_0040, 2'b00, "R4 last-outcome learned, R3 R7 history folded");
        look(32'h0000_0040, 2'b01, "R2 force not-taken over trained entry");
        look(32'h0000_0080, 2'b00, "R7 history held without update");
        // R9: train while forced, then check dynamic.
        step(32'h0000_0200, 2'b01, 1'b1, 32'h0000_0300, m_gidx(32'h300), 1'b1,
             "R9 forced mode during update");
        look(32'h0000_0300, 2'b00, "R9 training happened under forced mode");
        step(32'h0000_0300, 2'b10, 1'b1, 32'h0000_0300, m_gidx(32'h300), 1'b0,
             "R9 force taken during update");
        look(32'h0000_0300, 2'b00, "R4 R9 entry overwritten with not-taken");

        // R5 R6: mixed branch stream, updates resolved two cycles later.
        for (int n = 0; n < 400; n++) begin
            int k;
            logic tk;
            logic [1:0] md;
            pend_t p, u;
            logic uv;
            k  = int'($urandom_range(0, 7));
            md = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 2)) : 2'b00;
            cnt[k]++;
            case (k % 3)
                0: tk = (cnt[k] % 4) != 0;
                1: tk = m_hist[0];
                default: tk = 1'($urandom_range(0, 1));
            endcase
            p.pc = pcs[k]; p.g = m_gidx(pcs[k]); p.tk = tk;
            pend_q.push_back(p);
            uv = 1'b0;
            u  = p;
            if (pend_q.size() > 2) begin
                u  = pend_q.pop_front();
                uv = 1'b1;
            end
            step(pcs[k], md, uv, u.pc, u.g, u.tk,
                 "R5 R6 chooser and history-table stream");
        end
        look(32'h0000_0040, 2'b00, "R6 final lookup");

        #1;
        up_valid_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule